// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block keeps a small table of loads that were issued ahead of possibly conflicting stores. When such an early load is issued, the pipeline records its byte address, its access size and the number of the register it wrote. Every later store reports its own address and size on a snoop port. Every tracked load whose byte range shares at least one byte with the store is dropped from the table.

When the loaded value is about to be consumed, a check port looks the register up. A hit means no overlapping store has been seen since the load, so the early data can be used. A miss means the load has to be issued again. A hit can also retire its entry on request. When the table is full, a round-robin pointer picks the entry to overwrite.

The table is searched by register number on the load and check ports, and by address range on the snoop port. Each entry has its own comparators, so all three ports are served in the same cycle.

Top module: `spec_load_table`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `chk_done` and `chk_ok` are 0 and the table holds no valid entry. A check issued right after reset reports a miss.
- R2: A load recorded on the load port can be checked afterwards. A check raised in cycle N drives `chk_done`=1 in cycle N+1. In that cycle `chk_ok` is 1 when a valid entry holds `chk_reg`. `chk_done` is 0 in every cycle that does not follow a check.
- R3: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. A store at [s, s+bytes) invalidates every entry whose range [a, a+bytes) intersects it, and leaves every other entry valid.
- R4: A check for a register with no valid entry gives `chk_done`=1 and `chk_ok`=0.
- R5: A check that hits with `chk_clear`=1 invalidates the entry, so the next check of that register misses. With `chk_clear`=0 the entry stays valid.
- R6: Recording a load for a register that already has a valid entry overwrites that entry. After that, only the new address range is compared against stores.
- R7: A new register goes into the lowest-numbered free entry. When no entry is free, it overwrites the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, with wrap-around, only on allocations that find the table full.
- R8: When a store and a load record happen in the same cycle, the store is applied first. The newly recorded load stays valid even when its range overlaps the store.
- R9: A check reports the table as it was at the start of its cycle. A store, a clear or a load record in that same cycle does not change its result.
- R10: No two valid entries ever hold the same register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Record a speculative load this cycle |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_size | input | 2 | Size code of the load |
| ld_reg | input | REG_W | Destination register of the load |
| st_valid | input | 1 | A store is snooped this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | Look up a register this cycle |
| chk_reg | input | REG_W | Register to look up |
| chk_clear | input | 1 | Invalidate the entry if the lookup hits |
| chk_done | output | 1 | Response to the check of the previous cycle |
| chk_ok | output | 1 | 1: speculative data still good; 0: reissue the load |

## Verification
Two pairs of functions can land in the same cycle: a store snoop with a load record, and a store or load with a check. The bench drives a load and an overlapping store in one cycle and expects a hit on the next check. It also drives a check together with an overlapping store, and separately a check together with a load of the same register. In both of those cases the response must show the table from before that cycle, and a follow-up check must show the table after it. The overlap rule is swept over every pair of sizes, with store addresses on both sides of the load range.

// File: rtl/slt_pkg.sv
package slt_pkg;
   localparam int SIZE_CODE_W = 2;

   // Byte count for a size code: 1, 2, 4 or 8.
   function automatic logic [3:0] code_bytes(input logic [SIZE_CODE_W-1:0] code);
      return 4'd1 << code;
   endfunction
endpackage

// File: rtl/slt_entry.sv
module slt_entry
   import slt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [SIZE_CODE_W-1:0] wr_size,
   input  logic [REG_W-1:0]       wr_reg,
   input  logic                   kill,
   input  logic                   st_valid,
   input  logic [ADDR_W-1:0]      st_addr,
   input  logic [SIZE_CODE_W-1:0] st_size,
   input  logic [REG_W-1:0]       ld_probe,
   input  logic [REG_W-1:0]       chk_probe,
   output logic                   vld,
   output logic                   ld_match,
   output logic                   chk_match
);
   localparam int EXT_W = ADDR_W + 1;

   logic [ADDR_W-1:0]      e_addr;
   logic [SIZE_CODE_W-1:0] e_size;
   logic [REG_W-1:0]       e_reg;
   logic [EXT_W-1:0]       e_lo, e_hi, s_lo, s_hi;
   logic                   overlap;

   // Ends are computed one bit wider so that a range at the top of memory does not wrap.
   always_comb begin
      e_lo    = {1'b0, e_addr};
      e_hi    = e_lo + EXT_W'(code_bytes(e_size));
      s_lo    = {1'b0, st_addr};
      s_hi    = s_lo + EXT_W'(code_bytes(st_size));
      overlap = st_valid && vld && (s_lo < e_hi) && (e_lo < s_hi);
   end

   assign ld_match  = vld && (e_reg == ld_probe);
   assign chk_match = vld && (e_reg == chk_probe);

   // A write takes priority, so a store in the same cycle cannot kill the new load.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         e_addr <= '0;
         e_size <= '0;
         e_reg  <= '0;
      end else if (wr_en) begin
         vld    <= 1'b1;
         e_addr <= wr_addr;
         e_size <= wr_size;
         e_reg  <= wr_reg;
      end else if (kill || overlap) begin
         vld    <= 1'b0;
      end
   end
endmodule

// File: rtl/slt_victim_ptr.sv
module slt_victim_ptr #(
   parameter int ENTRIES = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance,
   output logic [ENTRIES-1:0] victim
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam bit POW2  = (ENTRIES == (1 << IDX_W));

   logic [IDX_W-1:0] ptr, ptr_nxt;

   generate
      if (POW2) begin : g_wrap_free
         assign ptr_nxt = ptr + IDX_W'(1);
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + IDX_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (advance) ptr <= ptr_nxt;
   end

   always_comb begin
      victim = '0;
      victim[ptr] = 1'b1;
   end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
   import slt_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int ADDR_W  = 32,
   parameter int REG_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [1:0]        ld_size,
   input  logic [REG_W-1:0]  ld_reg,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [1:0]        st_size,
   input  logic              chk_valid,
   input  logic [REG_W-1:0]  chk_reg,
   input  logic              chk_clear,
   output logic              chk_done,
   output logic              chk_ok
);
   generate
      if (ENTRIES < 2)    begin : g_bad_entries $error("ENTRIES must be at least 2"); end
      if (ADDR_W < 4)     begin : g_bad_addr    $error("ADDR_W must be at least 4"); end
      if (REG_W < 1)      begin : g_bad_reg     $error("REG_W must be at least 1"); end
      if (SIZE_CODE_W != 2) begin : g_bad_size  $error("size code must be 2 bits"); end
   endgenerate

   logic [ENTRIES-1:0] ent_vld, ld_hit, chk_hit, wr_sel, kill, free, first_free, victim;
   logic               full_alloc;

   assign free       = ~ent_vld;
   assign first_free = free & (~free + ENTRIES'(1));
   assign full_alloc = ld_valid && !(|ld_hit) && !(|free);

   // Existing entry for the register, else the lowest free entry, else the round-robin victim.
   always_comb begin
      if (|ld_hit)    wr_sel = ld_hit;
      else if (|free) wr_sel = first_free;
      else            wr_sel = victim;
   end

   assign kill = (chk_valid && chk_clear) ? chk_hit : '0;

   slt_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (full_alloc),
      .victim  (victim)
   );

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      slt_entry #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (ld_valid && wr_sel[i]),
         .wr_addr   (ld_addr),
         .wr_size   (ld_size),
         .wr_reg    (ld_reg),
         .kill      (kill[i]),
         .st_valid  (st_valid),
         .st_addr   (st_addr),
         .st_size   (st_size),
         .ld_probe  (ld_reg),
         .chk_probe (chk_reg),
         .vld       (ent_vld[i]),
         .ld_match  (ld_hit[i]),
         .chk_match (chk_hit[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_done <= 1'b0;
         chk_ok   <= 1'b0;
      end else begin
         chk_done <= chk_valid;
         chk_ok   <= chk_valid && (|chk_hit);
      end
   end
endmodule

// File: rtl/slt_chk.sv
module slt_chk #(
   parameter int ENTRIES = 32,
   parameter int REG_W   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ld_valid,
   input logic [REG_W-1:0]   ld_reg,
   input logic               chk_valid,
   input logic [REG_W-1:0]   chk_reg,
   input logic               chk_done,
   input logic               chk_ok,
   input logic [ENTRIES-1:0] ent_vld,
   input logic [ENTRIES-1:0] chk_hit
);
   // R2
   check_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> chk_done);

   // R2
   done_only_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !chk_done);

   // R10
   unique_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chk_hit));

   // R8
   record_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> (ent_vld != '0));

   // R9
   fresh_load_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && $past(ld_valid) && (chk_reg == $past(ld_reg)) && $past(rst_n)) |=> chk_ok);
endmodule

bind spec_load_table slt_chk #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_slt_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_valid  (ld_valid),
   .ld_reg    (ld_reg),
   .chk_valid (chk_valid),
   .chk_reg   (chk_reg),
   .chk_done  (chk_done),
   .chk_ok    (chk_ok),
   .ent_vld   (ent_vld),
   .chk_hit   (chk_hit)
);

// File: tb/test_spec_load_table.sv
module test_spec_load_table;
   localparam int ENTRIES = 4;
   localparam int ADDR_W  = 16;
   localparam int REG_W   = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ld_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0, chk_clear = 1'b0;
   logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0;
   logic [1:0]        ld_size = '0, st_size = '0;
   logic [REG_W-1:0]  ld_reg = '0, chk_reg = '0;
   logic              chk_done, chk_ok;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   spec_load_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .REG_W(REG_W)) i_spec_load_table (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size), .ld_reg(ld_reg),
      .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
      .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
      .chk_done(chk_done), .chk_ok(chk_ok)
   );

   task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0; chk_clear = 1'b0;
   endtask

   // All drive tasks start just after a falling edge and end at the next one.
   task automatic step();
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic set_load(input int r, input int a, input int s);
      ld_valid = 1'b1; ld_reg = REG_W'(r); ld_addr = ADDR_W'(a); ld_size = 2'(s);
   endtask

   task automatic set_store(input int a, input int s);
      st_valid = 1'b1; st_addr = ADDR_W'(a); st_size = 2'(s);
   endtask

   task automatic set_check(input int r, input bit clr);
      chk_valid = 1'b1; chk_reg = REG_W'(r); chk_clear = clr;
   endtask

   task automatic do_load(input int r, input int a, input int s);
      set_load(r, a, s); step();
   endtask

   task automatic do_check(input string req, input int r, input bit clr, input bit exp_ok);
      set_check(r, clr); step();
      expect_bit(req, "chk_done", chk_done, 1'b1);
      expect_bit(req, $sformatf("chk_ok reg %0d", r), chk_ok, exp_ok);
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R1: outputs quiet in the first cycle after reset, table empty.
      step();
      expect_bit("R1", "chk_done after reset", chk_done, 1'b0);
      expect_bit("R1", "chk_ok after reset", chk_ok, 1'b0);
      do_check("R1", 3, 1'b0, 1'b0);
      // R2: no response without a check.
      step();
      expect_bit("R2", "chk_done idle", chk_done, 1'b0);

      // R2 / R5: hit, keep, then clear.
      do_load(5, 64, 2);
      do_check("R2", 5, 1'b0, 1'b1);
      do_check("R5", 5, 1'b0, 1'b1);
      do_check("R5", 5, 1'b1, 1'b1);
      do_check("R5", 5, 1'b0, 1'b0);
      // R4: a register never recorded misses.
      do_check("R4", 77, 1'b0, 1'b0);

      // R3: sweep all size pairs and store positions around a load at 100.
      for (int ls = 0; ls < 4; ls++) begin
         for (int ss = 0; ss < 4; ss++) begin
            for (int sa = 88; sa < 112; sa++) begin
               int  lb, sb;
               bit  ovl;
               lb  = 1 << ls;
               sb  = 1 << ss;
               ovl = (sa < 100 + lb) && (100 < sa + sb);
               do_load(9, 100, ls);
               set_store(sa, ss); step();
               do_check($sformatf("R3 ls%0d ss%0d sa%0d", ls, ss, sa), 9, 1'b1, !ovl);
            end
         end
      end

      // R6: re-recording moves the tracked range; one entry only (R10).
      do_reset();
      do_load(7, 200, 0);
      do_load(7, 300, 3);
      set_store(200, 0); step();
      do_check("R6", 7, 1'b1, 1'b1);
      do_check("R10", 7, 1'b0, 1'b0);
      do_load(7, 400, 0);
      do_load(7, 500, 0);
      set_store(500, 0); step();
      do_check("R6", 7, 1'b0, 1'b0);

      // R7: fill the four entries, then round-robin from entry 0.
      do_reset();
      for (int r = 1; r <= 4; r++) do_load(r, 16 * r, 0);
      do_load(5, 1000, 0);              // full: overwrites entry 0 (reg 1)
      do_check("R7", 1, 1'b0, 1'b0);
      do_check("R7", 5, 1'b0, 1'b1);
      do_load(6, 1100, 0);              // full: overwrites entry 1 (reg 2)
      do_check("R7", 2, 1'b0, 1'b0);
      do_check("R7", 3, 1'b0, 1'b1);
      do_check("R7", 4, 1'b0, 1'b1);
      do_check("R7", 5, 1'b1, 1'b1);    // frees entry 0
      do_load(7, 1200, 0);              // free entry used, pointer stays at 2
      do_check("R7", 3, 1'b0, 1'b1);
      do_load(8, 1300, 0);              // full: overwrites entry 2 (reg 3)
      do_check("R7", 3, 1'b0, 1'b0);
      do_check("R7", 4, 1'b0, 1'b1);
      do_check("R7", 7, 1'b0, 1'b1);
      do_check("R7", 6, 1'b0, 1'b1);

      // R8: store and overlapping load in one cycle: the load survives.
      do_reset();
      set_load(11, 600, 3); set_store(602, 1); step();
      do_check("R8", 11, 1'b0, 1'b1);
      set_store(602, 1); step();
      do_check("R8", 11, 1'b0, 1'b0);

      // R9: check sees the table from before its own cycle.
      do_load(12, 700, 2);
      set_check(12, 1'b0); set_store(700, 0); step();
      expect_bit("R9", "chk_ok with same-cycle store", chk_ok, 1'b1);
      do_check("R9", 12, 1'b0, 1'b0);
      set_check(13, 1'b0); set_load(13, 800, 0); step();
      expect_bit("R9", "chk_ok with same-cycle load", chk_ok, 1'b0);
      do_check("R9", 13, 1'b0, 1'b1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule